// File: doc/BRIEF.md
# Direct-Mapped Data Cache Store Path with Delayed Write

This block is the memory-stage front end of a direct-mapped, write-through, write-allocate data cache. It is built so that a store which hits the cache finishes in one cycle. The tag check and the data-array write are not done back to back. A hitting store only checks its tag, and its word, byte enables and address are parked in a one-entry delayed-write register. The parked data goes into the data array during the tag-check cycle of the next store that hits. The array is also written when any access misses, which empties the register before a refill can replace the line.

Loads read the tag and data arrays in the same cycle. If a load addresses the word held in the delayed-write register, the enabled bytes of that register replace the array bytes on the load data output, so a load never returns data older than the last store. Misses stall the requester: `hit_o` stays low while a refill port fetches the whole line. The refill writes the line and its tag, and the held request then hits. Each hitting store is also posted to memory on a separate write port, which always accepts it.

Top module: `dcache_store_path`

## Requirements
- R1: A store to a resident line has `hit_o` high in the same cycle it is presented. No stall cycle is added for the data write.
- R2: A byte address has four fields, from least to most significant: byte offset (log2 of DATA_W/8 bits), word-in-line offset (log2 WPL bits), line index (log2 LINES bits) and tag (the remaining upper bits). An access hits only when the indexed line is valid and its stored tag equals the address tag.
- R3: A hitting store leaves the data array unchanged in that cycle and is held in the delayed-write register. In the same cycle it posts a memory write carrying its word address (`addr_i` without the byte offset), data and byte enables. Back-to-back stores to one word keep program order.
- R4: A load whose word address equals the buffered word takes the enabled bytes from the buffer and the other bytes from the array. A load of any other word returns array data only.
- R5: The delayed-write register becomes valid only through a hitting store. It keeps its contents over idle cycles and loads, and it is invalidated once its contents are written into the array.
- R6: When an access misses while the register is valid, the register is written into the array in that miss cycle. The refill request is raised only after that, so a store parked before a miss is visible to later hits.
- R7: Byte enable bit b selects byte b, which is bits 8b+7 down to 8b. Only the enabled bytes of a store change the word, both in the array and on load bypass.
- R8: A miss raises `mem_rd_req_o` with the line address from the next cycle, and keeps it high until `mem_rd_ack_i`. The line is written when the acknowledge arrives, and the held request hits in the following cycle. `hit_o` stays low while the refill is outstanding.
- R9: After reset all lines are invalid, the register is empty, and no memory request is raised while `req_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, held stable until `hit_o` |
| we_i | input | 1 | 1 = store, 0 = load |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | DATA_W | Store data |
| be_i | input | DATA_W/8 | Store byte enables |
| hit_o | output | 1 | Access completes this cycle |
| rdata_o | output | DATA_W | Load data, valid with `hit_o` |
| mem_wr_o | output | 1 | Posted write-through strobe |
| mem_wr_addr_o | output | ADDR_W-log2(DATA_W/8) | Word address of the posted write |
| mem_wr_data_o | output | DATA_W | Posted write data |
| mem_wr_be_o | output | DATA_W/8 | Posted write byte enables |
| mem_rd_req_o | output | 1 | Line refill request |
| mem_rd_addr_o | output | ADDR_W-log2(DATA_W/8)-log2(WPL) | Line address being refilled |
| mem_rd_ack_i | input | 1 | Refill data valid |
| mem_rd_line_i | input | DATA_W*WPL | Refill line, word 0 in the low bits |

## Verification
The assertions check, on every cycle, that the refill request is never raised while the delayed-write register is valid. They also check that the register only becomes valid after a store hit and keeps its address on idle cycles. On the miss side, they check that no hit is reported while a refill is pending, that each hitting store posts a write, and that the request drops after the acknowledge. Whether the data returned is correct can only be shown by the scenarios. Loads after one store or after two stores to the same word test the byte-merging bypass. A parked store followed by a conflicting miss elsewhere tests the drain. A sweep stores and loads every word with varying byte enables and compares each load against a flat reference memory.

// File: rtl/dcsp_pkg.sv
package dcsp_pkg;
  typedef enum logic [0:0] {
    ST_RUN  = 1'b0,
    ST_FILL = 1'b1
  } fill_state_e;
endpackage

// File: rtl/dcsp_tag_store.sv
module dcsp_tag_store #(
  parameter int LINES = 16,
  parameter int TAG_W = 8,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_vld_o,
  output logic [TAG_W-1:0] rd_tag_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [TAG_W-1:0] wr_tag_i
);
  logic [LINES-1:0] vld_q;
  logic [TAG_W-1:0] tag_q [LINES];

  for (genvar l = 0; l < LINES; l++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) vld_q[l] <= 1'b0;
      else if (wr_en_i && wr_idx_i == IDX_W'(l)) vld_q[l] <= 1'b1;
    end
    always_ff @(posedge clk_i) begin
      if (wr_en_i && wr_idx_i == IDX_W'(l)) tag_q[l] <= wr_tag_i;
    end
  end

  assign rd_vld_o = vld_q[rd_idx_i];
  assign rd_tag_o = tag_q[rd_idx_i];
endmodule

// File: rtl/dcsp_data_store.sv
module dcsp_data_store #(
  parameter int LINES  = 16,
  parameter int WPL    = 2,
  parameter int DATA_W = 32,
  localparam int IDX_W  = $clog2(LINES),
  localparam int WOFF_W = $clog2(WPL),
  localparam int ENT_W  = IDX_W + WOFF_W,
  localparam int BE_W   = DATA_W / 8,
  localparam int LINE_W = DATA_W * WPL
) (
  input  logic              clk_i,
  input  logic [ENT_W-1:0]  rd_ent_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              wr_en_i,
  input  logic [ENT_W-1:0]  wr_ent_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [BE_W-1:0]   wr_be_i,
  input  logic              fill_en_i,
  input  logic [IDX_W-1:0]  fill_idx_i,
  input  logic [LINE_W-1:0] fill_line_i
);
  logic [DATA_W-1:0] mem_q [LINES*WPL];

  always_ff @(posedge clk_i) begin
    if (fill_en_i) begin
      for (int w = 0; w < WPL; w++) begin
        mem_q[{fill_idx_i, WOFF_W'(w)}] <= fill_line_i[w*DATA_W +: DATA_W];
      end
    end else if (wr_en_i) begin
      for (int b = 0; b < BE_W; b++) begin
        if (wr_be_i[b]) mem_q[wr_ent_i][b*8 +: 8] <= wr_data_i[b*8 +: 8];
      end
    end
  end

  assign rd_data_o = mem_q[rd_ent_i];
endmodule

// File: rtl/dcsp_store_buf.sv
module dcsp_store_buf #(
  parameter int WA_W   = 14,
  parameter int DATA_W = 32,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              clr_i,
  input  logic [WA_W-1:0]   ld_waddr_i,
  input  logic [DATA_W-1:0] ld_data_i,
  input  logic [BE_W-1:0]   ld_be_i,
  output logic              vld_o,
  output logic [WA_W-1:0]   waddr_o,
  output logic [DATA_W-1:0] data_o,
  output logic [BE_W-1:0]   be_o,
  input  logic [WA_W-1:0]   lk_waddr_i,
  input  logic [DATA_W-1:0] arr_data_i,
  output logic [DATA_W-1:0] merged_o
);
  logic              vld_q;
  logic [WA_W-1:0]   waddr_q;
  logic [DATA_W-1:0] data_q;
  logic [BE_W-1:0]   be_q;
  logic              match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q   <= 1'b0;
      waddr_q <= '0;
      data_q  <= '0;
      be_q    <= '0;
    end else if (load_i) begin
      vld_q   <= 1'b1;
      waddr_q <= ld_waddr_i;
      data_q  <= ld_data_i;
      be_q    <= ld_be_i;
    end else if (clr_i) begin
      vld_q <= 1'b0;
    end
  end

  assign match = vld_q && (waddr_q == lk_waddr_i);

  for (genvar b = 0; b < BE_W; b++) begin : g_lane
    assign merged_o[b*8 +: 8] = (match && be_q[b]) ? data_q[b*8 +: 8]
                                                   : arr_data_i[b*8 +: 8];
  end

  assign vld_o   = vld_q;
  assign waddr_o = waddr_q;
  assign data_o  = data_q;
  assign be_o    = be_q;
endmodule

// File: rtl/dcsp_fill_ctrl.sv
module dcsp_fill_ctrl
  import dcsp_pkg::*;
#(
  parameter int LA_W = 13
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            miss_i,
  input  logic [LA_W-1:0] line_addr_i,
  input  logic            ack_i,
  output logic            running_o,
  output logic            fill_en_o,
  output logic            rd_req_o,
  output logic [LA_W-1:0] fill_addr_o
);
  fill_state_e     state_q, state_d;
  logic [LA_W-1:0] addr_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:  if (miss_i) state_d = ST_FILL;
      ST_FILL: if (ack_i)  state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_RUN && miss_i) addr_q <= line_addr_i;
    end
  end

  assign running_o   = (state_q == ST_RUN);
  assign rd_req_o    = (state_q == ST_FILL);
  assign fill_en_o   = (state_q == ST_FILL) && ack_i;
  assign fill_addr_o = addr_q;
endmodule

// File: rtl/dcache_store_path.sv
module dcache_store_path #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LINES  = 16,
  parameter int WPL    = 2,
  localparam int BE_W   = DATA_W / 8,
  localparam int BOFF_W = $clog2(BE_W),
  localparam int WOFF_W = $clog2(WPL),
  localparam int IDX_W  = $clog2(LINES),
  localparam int ENT_W  = IDX_W + WOFF_W,
  localparam int TAG_W  = ADDR_W - ENT_W - BOFF_W,
  localparam int WA_W   = ADDR_W - BOFF_W,
  localparam int LA_W   = WA_W - WOFF_W,
  localparam int LINE_W = DATA_W * WPL
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [BE_W-1:0]   be_i,
  output logic              hit_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mem_wr_o,
  output logic [WA_W-1:0]   mem_wr_addr_o,
  output logic [DATA_W-1:0] mem_wr_data_o,
  output logic [BE_W-1:0]   mem_wr_be_o,
  output logic              mem_rd_req_o,
  output logic [LA_W-1:0]   mem_rd_addr_o,
  input  logic              mem_rd_ack_i,
  input  logic [LINE_W-1:0] mem_rd_line_i
);
  logic [WA_W-1:0]   waddr;
  logic [LA_W-1:0]   laddr;
  logic [TAG_W-1:0]  tag;
  logic [IDX_W-1:0]  idx;
  logic [ENT_W-1:0]  ent;

  logic              line_vld;
  logic [TAG_W-1:0]  line_tag;
  logic              lookup_hit;
  logic              running;
  logic              st_hit;
  logic              miss;
  logic              drain;

  logic              buf_vld;
  logic [WA_W-1:0]   buf_waddr;
  logic [DATA_W-1:0] buf_data;
  logic [BE_W-1:0]   buf_be;
  logic [DATA_W-1:0] arr_data;

  logic              fill_en;
  logic [LA_W-1:0]   fill_addr;

  // address split: tag | index | word offset | byte offset
  assign waddr = addr_i[ADDR_W-1:BOFF_W];
  assign laddr = waddr[WA_W-1:WOFF_W];
  assign tag   = waddr[WA_W-1 -: TAG_W];
  assign idx   = laddr[IDX_W-1:0];
  assign ent   = waddr[ENT_W-1:0];

  dcsp_tag_store #(
    .LINES (LINES),
    .TAG_W (TAG_W)
  ) u_tags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_idx_i (idx),
    .rd_vld_o (line_vld),
    .rd_tag_o (line_tag),
    .wr_en_i  (fill_en),
    .wr_idx_i (fill_addr[IDX_W-1:0]),
    .wr_tag_i (fill_addr[LA_W-1 -: TAG_W])
  );

  assign lookup_hit = line_vld && (line_tag == tag);
  assign hit_o      = req_i && running && lookup_hit;
  assign st_hit     = hit_o && we_i;
  assign miss       = req_i && running && !lookup_hit;
  // buffered store commits on the next store hit, or before any refill
  assign drain      = buf_vld && (st_hit || miss);

  dcsp_data_store #(
    .LINES  (LINES),
    .WPL    (WPL),
    .DATA_W (DATA_W)
  ) u_data (
    .clk_i       (clk_i),
    .rd_ent_i    (ent),
    .rd_data_o   (arr_data),
    .wr_en_i     (drain),
    .wr_ent_i    (buf_waddr[ENT_W-1:0]),
    .wr_data_i   (buf_data),
    .wr_be_i     (buf_be),
    .fill_en_i   (fill_en),
    .fill_idx_i  (fill_addr[IDX_W-1:0]),
    .fill_line_i (mem_rd_line_i)
  );

  dcsp_store_buf #(
    .WA_W   (WA_W),
    .DATA_W (DATA_W)
  ) u_buf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (st_hit),
    .clr_i      (drain),
    .ld_waddr_i (waddr),
    .ld_data_i  (wdata_i),
    .ld_be_i    (be_i),
    .vld_o      (buf_vld),
    .waddr_o    (buf_waddr),
    .data_o     (buf_data),
    .be_o       (buf_be),
    .lk_waddr_i (waddr),
    .arr_data_i (arr_data),
    .merged_o   (rdata_o)
  );

  dcsp_fill_ctrl #(
    .LA_W (LA_W)
  ) u_fill (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .miss_i      (miss),
    .line_addr_i (laddr),
    .ack_i       (mem_rd_ack_i),
    .running_o   (running),
    .fill_en_o   (fill_en),
    .rd_req_o    (mem_rd_req_o),
    .fill_addr_o (fill_addr)
  );

  assign mem_rd_addr_o = fill_addr;
  assign mem_wr_o      = st_hit;
  assign mem_wr_addr_o = waddr;
  assign mem_wr_data_o = wdata_i;
  assign mem_wr_be_o   = be_i;
endmodule

// File: rtl/dcsp_checks.sv
module dcsp_checks #(
  parameter int WA_W = 14
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_i,
  input logic            we_i,
  input logic            hit_o,
  input logic            mem_wr_o,
  input logic            mem_rd_req_o,
  input logic            mem_rd_ack_i,
  input logic            buf_vld_i,
  input logic [WA_W-1:0] buf_waddr_i
);
  // R6
  a_r6_fill_after_drain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_req_o |-> !buf_vld_i);

  // R5
  a_r5_set_by_store_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(buf_vld_i) |-> $past(req_i && we_i && hit_o));

  // R5
  a_r5_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_vld_i && !req_i) |=> (buf_vld_i && $stable(buf_waddr_i)));

  // R3
  a_r3_post_on_store_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && hit_o) |-> mem_wr_o);

  // R8
  a_r8_no_hit_while_filling: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_req_o |-> !hit_o);

  // R8
  a_r8_req_drops_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_req_o && mem_rd_ack_i) |=> !mem_rd_req_o);
endmodule

bind dcache_store_path dcsp_checks #(.WA_W(WA_W)) u_checks (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .we_i         (we_i),
  .hit_o        (hit_o),
  .mem_wr_o     (mem_wr_o),
  .mem_rd_req_o (mem_rd_req_o),
  .mem_rd_ack_i (mem_rd_ack_i),
  .buf_vld_i    (buf_vld),
  .buf_waddr_i  (buf_waddr)
);

// File: tb/dcache_store_path_test.sv
`timescale 1ns/1ps
module dcache_store_path_test;
  localparam int AW = 10;
  localparam int DW = 32;
  localparam int NW = 256;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [3:0]    be = '0;
  logic          hit;
  logic [31:0]   rdata;
  logic          mem_wr;
  logic [7:0]    mem_wr_addr;
  logic [31:0]   mem_wr_data;
  logic [3:0]    mem_wr_be;
  logic          mem_rd_req;
  logic [6:0]    mem_rd_addr;
  logic          mem_rd_ack = 1'b0;
  logic [63:0]   mem_rd_line;

  int checks = 0;
  int errors = 0;

  logic [31:0] ref_mem [NW];
  logic [31:0] mdl_mem [NW];
  int          lat_cnt = 0;

  logic        seen_wr;
  logic [7:0]  seen_wr_addr;

  always #2.5 clk = ~clk;

  dcache_store_path #(
    .ADDR_W (AW),
    .DATA_W (DW),
    .LINES  (8),
    .WPL    (2)
  ) uut (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .req_i         (req),
    .we_i          (we),
    .addr_i        (addr),
    .wdata_i       (wdata),
    .be_i          (be),
    .hit_o         (hit),
    .rdata_o       (rdata),
    .mem_wr_o      (mem_wr),
    .mem_wr_addr_o (mem_wr_addr),
    .mem_wr_data_o (mem_wr_data),
    .mem_wr_be_o   (mem_wr_be),
    .mem_rd_req_o  (mem_rd_req),
    .mem_rd_addr_o (mem_rd_addr),
    .mem_rd_ack_i  (mem_rd_ack),
    .mem_rd_line_i (mem_rd_line)
  );

  function automatic logic [31:0] init_word(int i);
    return (32'h0103_0507 * (i + 1)) ^ 32'h5A5A_0000;
  endfunction

  function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] nw, logic [3:0] m);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++) if (m[b]) r[b*8 +: 8] = nw[b*8 +: 8];
    return r;
  endfunction

  // memory model: posted writes and a 3-cycle refill
  assign mem_rd_line = {mdl_mem[{mem_rd_addr, 1'b1}], mdl_mem[{mem_rd_addr, 1'b0}]};

  always @(posedge clk) begin
    if (mem_wr) mdl_mem[mem_wr_addr] <= merge(mdl_mem[mem_wr_addr], mem_wr_data, mem_wr_be);
    mem_rd_ack <= 1'b0;
    if (mem_rd_req && !mem_rd_ack) begin
      if (lat_cnt == 2) begin
        mem_rd_ack <= 1'b1;
        lat_cnt    <= 0;
      end else begin
        lat_cnt <= lat_cnt + 1;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(input bit w, input int wa, input logic [31:0] d, input logic [3:0] m,
                        output logic [31:0] rd, output int cyc);
    @(negedge clk);
    req = 1'b1; we = w; addr = AW'(wa << 2); wdata = d; be = m;
    cyc = 0; rd = '0; seen_wr = 1'b0; seen_wr_addr = '0;
    forever begin
      #1;
      cyc++;
      if (hit) begin
        rd = rdata; seen_wr = mem_wr; seen_wr_addr = mem_wr_addr;
        break;
      end
      if (cyc > 50) break;
      @(negedge clk);
    end
    @(posedge clk);
    #1 req = 1'b0;
    if (w) ref_mem[wa] = merge(ref_mem[wa], d, m);
  endtask

  task automatic load_chk(input int wa, input string tag);
    logic [31:0] r;
    int c;
    access(1'b0, wa, '0, '0, r, c);
    check(r === ref_mem[wa], tag, r, ref_mem[wa]);
  endtask

  initial begin
    logic [31:0] r;
    int c;
    for (int i = 0; i < NW; i++) begin
      ref_mem[i] = init_word(i);
      mdl_mem[i] = init_word(i);
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(!hit && !mem_rd_req && !mem_wr, "R9 reset quiet", {29'd0, hit, mem_rd_req, mem_wr}, 32'd0);

    // word address bits: [7:4] tag, [3:1] index, [0] word in line
    access(1'b0, 8'h05, '0, '0, r, c);
    check(c > 1, "R8 cold load refills", c, 2);
    check(r === ref_mem[8'h05], "R2 load after refill", r, ref_mem[8'h05]);
    access(1'b0, 8'h04, '0, '0, r, c);
    check(c == 1, "R2 same line hits", c, 1);
    check(r === ref_mem[8'h04], "R2 neighbour word", r, ref_mem[8'h04]);

    access(1'b1, 8'h05, 32'hDEAD_BEEF, 4'hF, r, c);
    check(c == 1, "R1 store hit single cycle", c, 1);
    check(seen_wr && seen_wr_addr == 8'h05, "R3 posted write", {23'd0, seen_wr, seen_wr_addr}, {23'd0, 1'b1, 8'h05});
    load_chk(8'h05, "R4 bypass full word");

    access(1'b1, 8'h05, 32'h1122_3344, 4'b0010, r, c);
    access(1'b1, 8'h05, 32'h5566_7788, 4'b0100, r, c);
    load_chk(8'h05, "R7 back-to-back partial stores");
    load_chk(8'h04, "R4 no bypass on other word");

    // parked store, then a miss elsewhere must drain it
    access(1'b1, 8'h04, 32'hCAFE_F00D, 4'b1001, r, c);
    access(1'b1, 8'h1B, 32'h0BAD_0BAD, 4'hF, r, c);
    check(c > 1, "R6 store miss stalls", c, 2);
    access(1'b0, 8'h04, '0, '0, r, c);
    check(c == 1, "R6 drained line resident", c, 1);
    check(r === ref_mem[8'h04], "R6 drained data in array", r, ref_mem[8'h04]);
    load_chk(8'h1B, "R8 store after allocate");

    // conflict: same index, other tag
    access(1'b0, 8'h15, '0, '0, r, c);
    check(c > 1, "R2 tag mismatch misses", c, 2);
    check(r === ref_mem[8'h15], "R2 conflict data", r, ref_mem[8'h15]);

    // sweep of every word with rotating byte enables
    for (int w = 0; w < NW; w++) begin
      access(1'b1, w, init_word(w + 77) ^ 32'hA5C3_0F96, 4'((w % 15) + 1), r, c);
      load_chk(w, "R7 sweep store-load");
      load_chk(w ^ 1, "R4 sweep neighbour");
      if ((w % 8) == 3) begin
        load_chk(w ^ 8'h30, "R6 sweep conflict");
        load_chk(w, "R6 sweep reload");
      end
    end
    for (int w = 0; w < NW; w++) load_chk(w, "R2 final pass");
    for (int w = 0; w < NW; w++)
      check(mdl_mem[w] === ref_mem[w], "R3 write-through image", mdl_mem[w], ref_mem[w]);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule